// File: doc/BRIEF.md
# Paging Batch Transmit Framer

This block turns a queue of ready-made 32-bit paging codewords into the serial bit stream of one transmission. A transmission opens with a long preamble of alternating ones and zeros. One or more batches follow. Each batch is a synchronisation word and then sixteen codeword slots, taken as eight frames of two slots each. The bit-rate clock lives elsewhere. The framer moves one bit along on each cycle in which `bit_en` is high.

Each queued codeword carries three tags: an address/message flag, a 3-bit target frame, and a last-word flag. An address codeword waits for the first free slot inside its target frame. If that frame has already gone by in the current batch, the address waits for the next batch. A message codeword goes out in the slot directly after the previous one, and it may run across frame and batch boundaries. Every slot left without content carries the idle pattern. Once the last word is out, the current batch is completed with idle words and the framer returns to rest.

Top module: `pager_batch_framer`

## Requirements
- R1: Out of reset and between transmissions, `busy`, `tx_bit` and `in_ready` are all 0.
- R2: A transmission starts when `in_valid` is seen at rest. It begins with 576 bits alternating 1,0,1,0…, and the first bit is 1.
- R3: Each batch sends the sync word 0x7CD215D8 and then exactly 16 codeword slots. Slot n belongs to frame n/2.
- R4: Sync words and codewords are shifted out most significant bit first.
- R5: An address codeword (`in_addr`=1) with target frame f (`in_frame`, 0..7) goes out in the first free slot that belongs to frame f.
- R6: A slot with no queued content carries the idle word 0x7A89C197. This also covers the second slot of a frame that holds only an address.
- R7: A message codeword (`in_addr`=0) goes out in the slot right after the previous word, across frame and batch boundaries.
- R8: If the next address targets a frame earlier than the current one, the rest of the batch is filled with idle words and the address is placed in the following batch.
- R9: `busy` stays high until the batch holding the word marked `in_last` has ended, then it drops to 0. The next transmission starts again with a preamble.
- R10: While `busy` is high, `tx_bit` changes only after a cycle in which `bit_en` was high.
- R11: `in_ready` is high only in a cycle with `bit_en` and `in_valid` both high. That cycle is the one in which the word is taken into a slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Bit-rate strobe; one output bit per high cycle |
| in_valid | input | 1 | Queue head holds a codeword |
| in_ready | output | 1 | Queue head is accepted this cycle |
| in_word | input | 32 | Encoded codeword |
| in_addr | input | 1 | 1 = address codeword, 0 = message codeword |
| in_frame | input | 3 | Target frame of an address codeword |
| in_last | input | 1 | Final codeword of this transmission |
| tx_bit | output | 1 | Serial output bit |
| busy | output | 1 | Transmission in progress |

## Verification
The bench builds the framer with its default parameters: a 576-bit preamble, 32-bit words and 16 slots. With these values every frame number can be targeted, and a short queue reaches a full three-batch transmission. That transmission includes an address that must wrap to the next batch, a message that spans a batch boundary, and an address that ends up alone in its frame. A second, one-word transmission follows straight after. It exercises the return to rest and the restart with a fresh preamble. It also contains a pause of the bit strobe in the middle of its preamble.

// File: rtl/pager_batch_framer.sv
module pager_batch_framer #(
  parameter int          PRE_BITS  = 576,
  parameter int          W         = 32,
  parameter int          SLOTS     = 16,
  parameter int          FW        = 3,
  parameter logic [31:0] IDLE_WORD = 32'h7A89C197,
  parameter logic [31:0] SYNC_WORD = 32'h7CD215D8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_en,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [W-1:0]  in_word,
  input  logic          in_addr,
  input  logic [FW-1:0] in_frame,
  input  logic          in_last,
  output logic          tx_bit,
  output logic          busy
);
  localparam int PW = $clog2(PRE_BITS);
  localparam int BW = $clog2(W);
  localparam int CW = (PW > BW) ? PW : BW;
  localparam int SW = $clog2(SLOTS);

  typedef enum logic [1:0] {S_IDLE, S_PRE, S_SYNC, S_WORD} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [SW-1:0] slot;
  logic [W-1:0]  sreg;
  logic          done;

  wire           word_end  = bit_en && cnt == CW'(W - 1);
  wire           load_slot = word_end && (st == S_SYNC ||
                             (st == S_WORD && slot != SW'(SLOTS - 1)));
  wire [SW-1:0]  nslot     = (st == S_SYNC) ? '0 : slot + 1'b1;
  wire           fits      = !in_addr || in_frame == FW'(nslot >> 1);

  assign in_ready = load_slot && in_valid && fits && !done;
  assign busy     = st != S_IDLE;
  assign tx_bit   = (st == S_PRE)  ? ~cnt[0] :
                    (st == S_IDLE) ? 1'b0    : sreg[W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      cnt  <= '0;
      slot <= '0;
      sreg <= '0;
      done <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (in_valid) begin
          st   <= S_PRE;
          cnt  <= '0;
          done <= 1'b0;
        end
        S_PRE: if (bit_en) begin
          if (cnt == CW'(PRE_BITS - 1)) begin
            st   <= S_SYNC;
            cnt  <= '0;
            sreg <= SYNC_WORD;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: if (bit_en) begin
          if (word_end) begin
            cnt <= '0;
            if (load_slot) begin
              st   <= S_WORD;
              slot <= nslot;
              sreg <= in_ready ? in_word : IDLE_WORD;
              done <= done || (in_ready && in_last);
            end else if (done) begin
              st <= S_IDLE;
            end else begin
              st   <= S_SYNC;
              sreg <= SYNC_WORD;
            end
          end else begin
            cnt  <= cnt + 1'b1;
            sreg <= sreg << 1;
          end
        end
      endcase
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!tx_bit && !in_ready));

  assert_preamble_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PRE && bit_en && cnt != CW'(PRE_BITS - 1)) |=> tx_bit != $past(tx_bit));

  assert_batch_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(done) && $past(bit_en)));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bit_en) |=> ($stable(tx_bit) && busy));

  assert_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (bit_en && in_valid && busy));
endmodule

// File: tb/test_pager_batch_framer.sv
module test_pager_batch_framer;
  logic clk = 1'b0, rst_n = 1'b0, bit_en = 1'b0, in_valid = 1'b0;
  logic in_addr = 1'b0, in_last = 1'b0;
  logic [2:0]  in_frame = '0;
  logic [31:0] in_word = '0;
  logic in_ready, tx_bit, busy;

  localparam logic [31:0] IDLE = 32'h7A89C197;
  localparam logic [31:0] SYNC = 32'h7CD215D8;
  localparam int N = 11;
  // {last, addr, frame, word}
  localparam logic [36:0] VEC [N] = '{
    {1'b0, 1'b1, 3'd3, 32'h12345678},
    {1'b0, 1'b0, 3'd0, 32'h80000001},
    {1'b0, 1'b0, 3'd0, 32'h8AAAAAAA},
    {1'b0, 1'b1, 3'd4, 32'h01111111},
    {1'b0, 1'b1, 3'd2, 32'h02222222},
    {1'b0, 1'b1, 3'd7, 32'h03333333},
    {1'b0, 1'b0, 3'd0, 32'h85555555},
    {1'b0, 1'b0, 3'd0, 32'hC0FFEE01},
    {1'b0, 1'b1, 3'd0, 32'h04444444},
    {1'b1, 1'b1, 3'd5, 32'h05555554},
    {1'b1, 1'b1, 3'd0, 32'h06666666}};

  int errors = 0, checks = 0;
  logic cap_bits [8192];
  int cap_cnt = 0, bad_ready = 0, ph = 0;
  logic hold = 1'b0;
  logic [31:0] exp_word [256];
  string exp_tag [256];
  int exp_n = 0;

  pager_batch_framer i_pager_batch_framer (
    .clk, .rst_n, .bit_en, .in_valid, .in_ready, .in_word, .in_addr,
    .in_frame, .in_last, .tx_bit, .busy);

  always #10 clk = ~clk;

  always @(negedge clk) begin
    bit_en <= (ph == 0) && !hold;
    ph <= (ph == 2) ? 0 : ph + 1;
  end

  initial forever begin
    @(negedge clk); #5;
    if (in_ready && !bit_en) bad_ready++;
    if (busy && bit_en) begin cap_bits[cap_cnt] = tx_bit; cap_cnt++; end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  // R10: pause the strobe in the middle of the second preamble
  initial begin
    logic ref_bit;
    int moved;
    moved = 0;
    while (cap_cnt < 2208 + 300) @(negedge clk);
    hold = 1'b1;
    @(negedge clk); @(negedge clk);
    ref_bit = tx_bit;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (tx_bit !== ref_bit || !busy) moved++;
    end
    check("R10 output held without strobe", moved, 0);
    hold = 1'b0;
  end

  initial begin
    int idx, bp, pm;
    logic acc;
    logic [31:0] w;
    // build expected codeword list from the requirements
    idx = 0;
    for (int t = 0; t < 2; t++) begin
      bit fin;
      fin = 0;
      while (!fin) begin
        exp_word[exp_n] = SYNC; exp_tag[exp_n] = "R3"; exp_n++;
        for (int s = 0; s < 16; s++) begin
          if (idx < N && !(fin) && (!VEC[idx][35] || VEC[idx][34:32] == 3'(s / 2))) begin
            exp_word[exp_n] = VEC[idx][31:0];
            exp_tag[exp_n] = !VEC[idx][35] ? "R7" : (idx == 4 ? "R8" : "R5");
            if (VEC[idx][36]) fin = 1;
            idx++;
          end else begin
            exp_word[exp_n] = IDLE; exp_tag[exp_n] = "R6";
          end
          exp_n++;
        end
      end
    end

    // R1: reset state, even with a word offered
    {in_last, in_addr, in_frame, in_word} = VEC[0];
    in_valid = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 busy in reset", busy, 0);
    check("R1 tx_bit in reset", tx_bit, 0);
    check("R1 in_ready in reset", in_ready, 0);
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 busy at rest", busy, 0);
    check("R1 tx_bit at rest", tx_bit, 0);

    for (int i = 0; i < N; i++) begin
      {in_last, in_addr, in_frame, in_word} = VEC[i];
      in_valid = 1'b1;
      do begin
        #5; acc = in_ready;
        @(negedge clk);
      end while (!acc);
    end
    in_valid = 1'b0;
    while (busy) @(negedge clk);
    repeat (6) @(negedge clk);
    check("R9 busy after last batch", busy, 0);

    // R1 between/after transmissions: no spurious start without valid
    check("R1 tx_bit after end", tx_bit, 0);

    // compare stream: preamble, 4 batches split 3 + 1
    bp = 0;
    idx = 0;
    for (int t = 0; t < 2; t++) begin
      int nb;
      nb = (t == 0) ? 3 : 1;
      pm = 0;
      for (int k = 0; k < 576; k++)
        if (cap_bits[bp + k] !== ((k % 2 == 0) ? 1'b1 : 1'b0)) pm++;
      check("R2 preamble mismatches", pm, 0);
      bp += 576;
      if (t == 0)
        check("R4 first sync nibble sent MSB first",
              {cap_bits[bp], cap_bits[bp+1], cap_bits[bp+2], cap_bits[bp+3]}, 4'h7);
      for (int j = 0; j < nb * 17; j++) begin
        w = '0;
        for (int b = 0; b < 32; b++) w = {w[30:0], cap_bits[bp + b]};
        check({exp_tag[idx], " word"}, w, exp_word[idx]);
        bp += 32;
        idx++;
      end
    end
    check("R9 total bits", cap_cnt, 2 * 576 + 4 * 17 * 32);
    check("R3 batches expected", exp_n, 4 * 17);
    check("R11 ready without strobe", bad_ready, 0);
    finish_run();
  end
endmodule